// File: doc/BRIEF.md
# Three-Phase Stored-Program Processor

This block is a minimal stored-program processor. A control state machine walks every instruction through three phases (fetch, decode, execute) and then starts over. Instruction words come from an internal program memory, and the processor works on a sixteen-entry register file and an internal data memory. The block has three operations: a register-to-register add, a conditional jump that tests one register, and a load from data memory into a register. Every other opcode does nothing.

The surrounding environment fills both memories through a preload port, usually while reset is held. It then releases reset and lets the program run. Debug outputs show the instruction pointer and the current phase. A debug read port gives combinational access to any register, so results can be observed without a store instruction. Each instruction takes exactly three clock cycles.

Top module: `tri_phase_cpu`

## Requirements
- R1: A synchronous active-high reset clears the instruction pointer and all sixteen registers and puts the controller in the fetch phase. This state is visible on the first clock edge with reset high.
- R2: The phase output is encoded as fetch = 0, decode = 1, execute = 2. After reset it steps 0, 1, 2, 0 ... and changes on every clock edge.
- R3: In fetch, the word at the instruction pointer is latched and the pointer advances by exactly one, wrapping from 255 to 0. The pointer does not change in decode.
- R4: The instruction format is as follows. Bits [31:28] are the opcode. Bits [27:24], [23:20] and [19:16] are register fields A, B and C. Bits [15:0] are an address field, and only its low 8 bits select a memory word or jump target.
- R5: Opcode 0001 (add) writes register A + register B into register C, modulo 2^16. The destination may also be one of the sources.
- R6: Opcode 0010 (jump) loads the address field into the instruction pointer when register A, read as signed two's complement, is strictly greater than zero. This replaces the value advanced in fetch.
- R7: A jump whose register A is zero or negative (including 0x8000 and 0xFFFF) leaves the pointer at the next instruction.
- R8: Opcode 0011 (load) copies the data-memory word at the address field into register A.
- R9: Any other opcode (0000, 0100 to 1111) changes no register, and execution continues at the next instruction.
- R10: A preload write (pl_we = 1) at the clock edge stores pl_word at pl_addr. The target is program memory when pl_to_data = 0, and data memory (low 16 bits only) when pl_to_data = 1.
- R11: dbg_reg_val shows the register selected by dbg_reg_sel combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pl_we | input | 1 | Preload write strobe |
| pl_to_data | input | 1 | Preload target: 0 program memory, 1 data memory |
| pl_addr | input | 8 | Preload word address |
| pl_word | input | 32 | Preload data (data memory keeps bits [15:0]) |
| dbg_ip | output | 8 | Current instruction pointer |
| dbg_phase | output | 2 | Current phase: 0 fetch, 1 decode, 2 execute |
| dbg_reg_sel | input | 4 | Register index for the debug read |
| dbg_reg_val | output | 16 | Value of the selected register |

## Verification
The hardest case to reach from the ports is a jump that tests the signed boundary. To build it, the program loads 0x7FFF and 1, adds them so the result wraps to 0x8000, and then jumps on the result, which must not be taken. Zero, -1 and +1 are tested the same way. The pointer wrap from 255 to 0 is reached by a taken jump to 0xFE followed by two no-operation words. A reference model in the bench runs each program one instruction at a time, and its expected pointer trace is compared at every return to fetch.

// File: rtl/tpc_pkg.sv
`timescale 1ns/1ps
package tpc_pkg;
    localparam int INSTR_W   = 32;
    localparam int REG_IDX_W = 4;
    localparam int FIELD_A_W = 16;

    localparam logic [3:0] OPC_ADD  = 4'h1;
    localparam logic [3:0] OPC_JUMP = 4'h2;
    localparam logic [3:0] OPC_LOAD = 4'h3;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        K_NOP, K_ADD, K_JUMP, K_LOAD
    } op_kind_t;

    typedef struct packed {
        logic [3:0]           opcode;
        logic [REG_IDX_W-1:0] f_a;
        logic [REG_IDX_W-1:0] f_b;
        logic [REG_IDX_W-1:0] f_c;
        logic [FIELD_A_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        op_kind_t             kind;
        logic [REG_IDX_W-1:0] src_a;
        logic [REG_IDX_W-1:0] src_b;
        logic [REG_IDX_W-1:0] dst;
        logic [FIELD_A_W-1:0] addr;
    } dec_t;

    function automatic dec_t decode_instr(instr_t w);
        dec_t d;
        d.kind  = K_NOP;
        d.src_a = w.f_a;
        d.src_b = w.f_b;
        d.dst   = w.f_c;
        d.addr  = w.addr;
        case (w.opcode)
            OPC_ADD:  d.kind = K_ADD;
            OPC_JUMP: d.kind = K_JUMP;
            OPC_LOAD: begin
                d.kind = K_LOAD;
                d.dst  = w.f_a;
            end
            default:  d.kind = K_NOP;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/tpc_mem.sv
`timescale 1ns/1ps
module tpc_mem #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/tpc_regfile.sv
`timescale 1ns/1ps
module tpc_regfile #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 16,
    localparam int IW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IW-1:0]     wsel,
    input  logic [DATA_W-1:0] wval,
    input  logic [IW-1:0]     sel_a,
    input  logic [IW-1:0]     sel_b,
    input  logic [IW-1:0]     sel_dbg,
    output logic [DATA_W-1:0] val_a,
    output logic [DATA_W-1:0] val_b,
    output logic [DATA_W-1:0] val_dbg
);
    logic [DATA_W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wsel] <= wval;
        end
    end

    assign val_a   = regs[sel_a];
    assign val_b   = regs[sel_b];
    assign val_dbg = regs[sel_dbg];
endmodule

// File: rtl/tpc_ctrl.sv
`timescale 1ns/1ps
module tpc_ctrl
    import tpc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [ADDR_W-1:0]    pm_addr,
    input  logic [INSTR_W-1:0]   pm_word,
    output logic [ADDR_W-1:0]    dm_addr,
    input  logic [DATA_W-1:0]    dm_word,
    output logic [REG_IDX_W-1:0] rf_sel_a,
    output logic [REG_IDX_W-1:0] rf_sel_b,
    input  logic [DATA_W-1:0]    rf_val_a,
    input  logic [DATA_W-1:0]    rf_val_b,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_wsel,
    output logic [DATA_W-1:0]    rf_wval,
    output phase_t               phase,
    output logic [ADDR_W-1:0]    ip,
    output op_kind_t             kind,
    output logic [ADDR_W-1:0]    jump_tgt
);
    phase_t             phase_q;
    logic [ADDR_W-1:0]  ip_q;
    instr_t             ir_q;
    dec_t               dec_q;
    logic               take_jump;
    logic               unused_addr_hi;

    assign unused_addr_hi = ^dec_q.addr[FIELD_A_W-1:ADDR_W];

    // positive test: sign bit clear and value non-zero
    assign take_jump = (dec_q.kind == K_JUMP) && !rf_val_a[DATA_W-1] && (rf_val_a != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
            ip_q    <= '0;
            ir_q    <= '0;
            dec_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_FETCH: begin
                    ir_q    <= instr_t'(pm_word);
                    ip_q    <= ip_q + 1'b1;
                    phase_q <= PH_DECODE;
                end
                PH_DECODE: begin
                    dec_q   <= decode_instr(ir_q);
                    phase_q <= PH_EXEC;
                end
                PH_EXEC: begin
                    if (take_jump) ip_q <= dec_q.addr[ADDR_W-1:0];
                    phase_q <= PH_FETCH;
                end
                default: phase_q <= PH_FETCH;
            endcase
        end
    end

    always_comb begin
        pm_addr  = ip_q;
        dm_addr  = dec_q.addr[ADDR_W-1:0];
        rf_sel_a = dec_q.src_a;
        rf_sel_b = dec_q.src_b;
        rf_wsel  = dec_q.dst;
        rf_we    = (phase_q == PH_EXEC) && ((dec_q.kind == K_ADD) || (dec_q.kind == K_LOAD));
        rf_wval  = (dec_q.kind == K_ADD) ? (rf_val_a + rf_val_b) : dm_word;
    end

    assign phase    = phase_q;
    assign ip       = ip_q;
    assign kind     = dec_q.kind;
    assign jump_tgt = dec_q.addr[ADDR_W-1:0];
endmodule

// File: rtl/tri_phase_cpu.sv
`timescale 1ns/1ps
module tri_phase_cpu
    import tpc_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MEM_DEPTH = 256,
    localparam int ADDR_W   = $clog2(MEM_DEPTH),
    localparam int NREGS    = 2 ** REG_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pl_we,
    input  logic                 pl_to_data,
    input  logic [ADDR_W-1:0]    pl_addr,
    input  logic [INSTR_W-1:0]   pl_word,
    output logic [ADDR_W-1:0]    dbg_ip,
    output logic [1:0]           dbg_phase,
    input  logic [REG_IDX_W-1:0] dbg_reg_sel,
    output logic [DATA_W-1:0]    dbg_reg_val
);
    logic [ADDR_W-1:0]    pm_addr, dm_addr, ip_w, jump_tgt_w;
    logic [INSTR_W-1:0]   pm_word;
    logic [DATA_W-1:0]    dm_word, rf_a, rf_b, rf_wval;
    logic [REG_IDX_W-1:0] rf_sel_a, rf_sel_b, rf_wsel;
    logic                 rf_we_w;
    phase_t               phase_w;
    op_kind_t             kind_w;
    logic                 unused_pl_hi;

    assign unused_pl_hi = ^pl_word[INSTR_W-1:DATA_W];

    tpc_mem #(.WIDTH(INSTR_W), .DEPTH(MEM_DEPTH)) u_pmem (
        .clk(clk), .we(pl_we && !pl_to_data), .waddr(pl_addr), .wdata(pl_word),
        .raddr(pm_addr), .rdata(pm_word)
    );

    tpc_mem #(.WIDTH(DATA_W), .DEPTH(MEM_DEPTH)) u_dmem (
        .clk(clk), .we(pl_we && pl_to_data), .waddr(pl_addr), .wdata(pl_word[DATA_W-1:0]),
        .raddr(dm_addr), .rdata(dm_word)
    );

    tpc_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we_w), .wsel(rf_wsel), .wval(rf_wval),
        .sel_a(rf_sel_a), .sel_b(rf_sel_b), .sel_dbg(dbg_reg_sel),
        .val_a(rf_a), .val_b(rf_b), .val_dbg(dbg_reg_val)
    );

    tpc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .pm_addr(pm_addr), .pm_word(pm_word),
        .dm_addr(dm_addr), .dm_word(dm_word),
        .rf_sel_a(rf_sel_a), .rf_sel_b(rf_sel_b), .rf_val_a(rf_a), .rf_val_b(rf_b),
        .rf_we(rf_we_w), .rf_wsel(rf_wsel), .rf_wval(rf_wval),
        .phase(phase_w), .ip(ip_w), .kind(kind_w), .jump_tgt(jump_tgt_w)
    );

    assign dbg_ip    = ip_w;
    assign dbg_phase = phase_w;
endmodule

// File: rtl/tpc_checker.sv
`timescale 1ns/1ps
module tpc_checker
    import tpc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input phase_t            phase,
    input logic [ADDR_W-1:0] ip,
    input op_kind_t          kind,
    input logic [DATA_W-1:0] test_val,
    input logic [ADDR_W-1:0] jump_tgt,
    input logic              rf_we
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (ip == '0) && (phase == PH_FETCH));

    p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (phase == PH_DECODE));
    p_decode_to_exec_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DECODE) |=> (phase == PH_EXEC));
    p_exec_to_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC) |=> (phase == PH_FETCH));

    p_fetch_step_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (ip == ($past(ip) + 1'b1)));
    p_decode_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DECODE) |=> $stable(ip));

    p_jump_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && kind == K_JUMP && ($signed(test_val) > $signed({DATA_W{1'b0}})))
        |=> (ip == $past(jump_tgt)));
    p_jump_skip_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && kind == K_JUMP && !($signed(test_val) > $signed({DATA_W{1'b0}})))
        |=> $stable(ip));

    p_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        (kind == K_NOP || kind == K_JUMP || phase != PH_EXEC) |-> !rf_we);
    p_nop_ip_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && kind != K_JUMP) |=> $stable(ip));
endmodule

bind tri_phase_cpu tpc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .phase(phase_w), .ip(ip_w), .kind(kind_w),
    .test_val(rf_a), .jump_tgt(jump_tgt_w), .rf_we(rf_we_w)
);

// File: tb/tri_phase_cpu_test.sv
`timescale 1ns/1ps
module tri_phase_cpu_test;
    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pl_we = 1'b0;
    logic          pl_to_data = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [31:0]   pl_word = '0;
    logic [AW-1:0] dbg_ip;
    logic [1:0]    dbg_phase;
    logic [3:0]    dbg_reg_sel = '0;
    logic [DW-1:0] dbg_reg_val;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    tri_phase_cpu uut (
        .clk(clk), .rst(rst), .pl_we(pl_we), .pl_to_data(pl_to_data),
        .pl_addr(pl_addr), .pl_word(pl_word), .dbg_ip(dbg_ip), .dbg_phase(dbg_phase),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val)
    );

    // reference model state
    logic [31:0]   m_pm [256];
    logic [DW-1:0] m_dm [256];
    logic [DW-1:0] m_rf [16];
    logic [AW-1:0] m_ip;

    // scoreboard queues
    logic [AW-1:0] exp_ip_q [$];
    string         exp_tag_q [$];

    function automatic logic [31:0] enc_add(int a, int b, int c);
        return {4'h1, 4'(a), 4'(b), 4'(c), 16'h0000};
    endfunction
    function automatic logic [31:0] enc_jump(int r, logic [15:0] tgt);
        return {4'h2, 4'(r), 8'h00, tgt};
    endfunction
    function automatic logic [31:0] enc_load(int r, logic [15:0] a);
        return {4'h3, 4'(r), 8'h00, a};
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic preload(logic to_data, logic [AW-1:0] a, logic [31:0] w);
        @(negedge clk);
        pl_we = 1'b1; pl_to_data = to_data; pl_addr = a; pl_word = w;
        @(negedge clk);
        pl_we = 1'b0;
        if (to_data) m_dm[a] = w[DW-1:0];
        else         m_pm[a] = w;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_rf[i] = '0;
        m_ip = '0;
    endtask

    task automatic model_step();
        logic [31:0] w;
        string       tag;
        w = m_pm[m_ip];
        m_ip = m_ip + 1'b1;
        case (w[31:28])
            4'h1: begin
                m_rf[w[19:16]] = m_rf[w[27:24]] + m_rf[w[23:20]];
                tag = "R5 add";
            end
            4'h2: begin
                if (!m_rf[w[27:24]][DW-1] && m_rf[w[27:24]] != '0) begin
                    m_ip = w[AW-1:0];
                    tag = "R6 jump taken";
                end else begin
                    tag = "R7 jump not taken";
                end
            end
            4'h3: begin
                m_rf[w[27:24]] = m_dm[w[AW-1:0]];
                tag = "R8 load";
            end
            default: tag = "R9 no-op";
        endcase
        exp_ip_q.push_back(m_ip);
        exp_tag_q.push_back(tag);
    endtask

    // driver: push the expected trace, release reset, run n instructions
    task automatic run_program(int n);
        for (int i = 0; i < n; i++) model_step();
        @(negedge clk);
        rst = 1'b0;
        #3;
        check("R2 phase after reset", {30'd0, dbg_phase}, 32'd0);
        for (int k = 1; k <= 3 * n; k++) begin
            @(negedge clk);
            #3;
            if (k <= 6) check("R2 phase sequence", {30'd0, dbg_phase}, 32'(k % 3));
        end
        #2;
        check("R3 scoreboard drained", 32'(exp_ip_q.size()), 32'd0);
    endtask

    task automatic read_reg(int idx, output logic [DW-1:0] v);
        dbg_reg_sel = 4'(idx);
        #1;
        v = dbg_reg_val;
    endtask

    // monitor: compare pointer at each return to fetch
    initial begin
        logic [1:0] prev;
        prev = 2'd0;
        forever begin
            @(negedge clk);
            #2;
            if (rst) begin
                prev = 2'd0;
            end else begin
                if (dbg_phase == 2'd0 && prev == 2'd2 && exp_ip_q.size() > 0) begin
                    logic [AW-1:0] e;
                    string t;
                    e = exp_ip_q.pop_front();
                    t = exp_tag_q.pop_front();
                    check({t, " (R3 pointer)"}, {24'd0, dbg_ip}, {24'd0, e});
                end
                prev = dbg_phase;
            end
        end
    end

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        for (int i = 0; i < 256; i++) begin m_pm[i] = '0; m_dm[i] = '0; end
        model_reset();
        repeat (3) @(negedge clk);
        #3;
        check("R1 reset pointer", {24'd0, dbg_ip}, 32'd0);
        check("R1 reset phase", {30'd0, dbg_phase}, 32'd0);
        read_reg(3, v);
        check("R1 reset register", {16'd0, v}, 32'd0);

        // data memory (R10: data side keeps low 16 bits)
        preload(1'b1, 8'd0, 32'h0000_0005);
        preload(1'b1, 8'd1, 32'h0000_0007);
        preload(1'b1, 8'd2, 32'h0000_FFFF);
        preload(1'b1, 8'd3, 32'h0000_0001);
        preload(1'b1, 8'd4, 32'h0000_7FFF);
        preload(1'b1, 8'd5, 32'hABCD_1234);
        // program 1
        preload(1'b0, 8'd0,  enc_load(1, 16'h0000));
        preload(1'b0, 8'd1,  enc_load(2, 16'h0001));
        preload(1'b0, 8'd2,  enc_add(1, 2, 3));
        preload(1'b0, 8'd3,  enc_load(4, 16'h0002));
        preload(1'b0, 8'd4,  enc_jump(4, 16'd20));
        preload(1'b0, 8'd5,  enc_jump(0, 16'd20));
        preload(1'b0, 8'd6,  enc_load(5, 16'h0004));
        preload(1'b0, 8'd7,  enc_load(6, 16'h0003));
        preload(1'b0, 8'd8,  enc_add(5, 6, 7));
        preload(1'b0, 8'd9,  enc_jump(7, 16'd20));
        preload(1'b0, 8'd10, enc_add(4, 4, 8));
        preload(1'b0, 8'd11, 32'hF123_0000);
        preload(1'b0, 8'd12, 32'h0000_0000);
        preload(1'b0, 8'd13, enc_jump(6, 16'h0114));
        preload(1'b0, 8'd14, enc_load(9, 16'h0000));
        preload(1'b0, 8'd20, enc_load(10, 16'hFF05));
        preload(1'b0, 8'd21, enc_add(3, 10, 3));
        preload(1'b0, 8'd22, enc_jump(6, 16'd22));

        run_program(20);

        read_reg(3, v);  check("R5 add with destination equal to source", {16'd0, v}, 32'h1240);
        read_reg(7, v);  check("R5 add wraps to 0x8000", {16'd0, v}, 32'h8000);
        read_reg(8, v);  check("R4 field order of add", {16'd0, v}, 32'hFFFE);
        read_reg(9, v);  check("R6 skipped instruction left r9", {16'd0, v}, 32'h0000);
        read_reg(10, v); check("R10 data preload low half", {16'd0, v}, 32'h1234);
        read_reg(4, v);  check("R8 load of 0xFFFF", {16'd0, v}, 32'hFFFF);
        for (int i = 0; i < 16; i++) begin
            read_reg(i, v);
            check($sformatf("R11 debug read r%0d", i), {16'd0, v}, {16'd0, m_rf[i]});
        end

        // mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #3;
        check("R1 reset clears pointer", {24'd0, dbg_ip}, 32'd0);
        check("R1 reset returns to fetch", {30'd0, dbg_phase}, 32'd0);
        read_reg(3, v);  check("R1 reset clears r3", {16'd0, v}, 32'd0);
        read_reg(10, v); check("R1 reset clears r10", {16'd0, v}, 32'd0);
        model_reset();

        // program 2: pointer wrap
        preload(1'b0, 8'd0,   enc_load(1, 16'h0003));
        preload(1'b0, 8'd1,   enc_jump(1, 16'h00FE));
        preload(1'b0, 8'd254, 32'h4000_0000);
        preload(1'b0, 8'd255, 32'h0000_0000);

        run_program(6);
        read_reg(1, v); check("R8 load after wrap", {16'd0, v}, 32'h0001);
        read_reg(5, v); check("R9 no-op opcodes left r5", {16'd0, v}, 32'h0000);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule